// File: doc/BRIEF.md
# Video Processor CPU Register Interface

This block is the register file that a CPU sees in front of a tile-based video processor. The CPU can write a control byte and a mask byte; these are never read back. The block breaks both bytes into named fields that drive the rest of the video pipeline. The CPU can also read a status byte that holds three event flags. The block raises the vertical-blank interrupt. It also keeps the 14-bit video-memory address, which advances by 1 or by 32 after each access to the data port.

The raster counter sends two single-cycle pulses: one when vertical blank starts and one when the pre-render line starts. The sprite logic sends single-cycle pulses that set the sprite-0 hit flag and the sprite overflow flag. Any byte the block does not drive reads back as the last value seen on the data bus. The block also applies the monochrome mask to palette values on their way out.

Top module: `vid_regif`

## Requirements
- R1: After a synchronous active-low reset the following are all 0: every control field, every mask field, `bus_active`, `nmi`, all status flags, `vaddr` and the open-bus latch.
- R2: A write to select 0 loads the control byte. The field order from bit 7 down to bit 0 is: `nmi_en`, `ext_out_en`, `spr_tall`, `bg_table`, `spr_table`, `step_wide`, then `nt_base[1:0]` in bits 1:0.
- R3: A write to select 1 loads the mask byte. Bits 7:5 go to `emph[2:0]` (blue, green, red). Bit 4 is `spr_en`, bit 3 is `bg_en`, bit 2 is `spr_left`, bit 1 is `bg_left` and bit 0 is `mono`.
- R4: Each read or write at select 7 adds `addr_step` to `vaddr`, modulo 16384. `addr_step` is 32 when `step_wide` is 1 and 1 otherwise. Accesses at any other select leave `vaddr` unchanged.
- R5: A `vblank_start` pulse sets the vblank flag. A read of select 2 clears it, and so does a `prerender_start` pulse.
- R6: `spr0_set` sets the sprite-0 hit flag and `ovf_set` sets the overflow flag. Reads of select 2 leave both flags set. A `prerender_start` pulse clears both.
- R7: A read of select 2 returns {vblank, sprite-0 hit, overflow, open-bus bits 4:0}. The value returned is the state of the flags before that read takes effect.
- R8: The open-bus latch captures the write data on every CPU write and the returned byte on every CPU read. A read of any select other than 2 returns the whole latch.
- R9: `nmi` equals `nmi_en` AND the vblank flag. If `nmi_en` is written to 1 while the flag is already set, `nmi` is 1 in the next cycle.
- R10: `pal_out` equals `pal_in` AND 0x30 when `mono` is 1, and equals `pal_in` when `mono` is 0.
- R11: `bus_active` is 1 exactly when `spr_en` or `bg_en` is 1.
- R12: When `vblank_start` arrives in the same cycle as a status read, the flag ends up set. When `prerender_start` arrives in the same cycle as `spr0_set` or `ovf_set`, the flag ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | CPU access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data |
| vblank_start | input | 1 | Pulse at the start of vertical blank |
| prerender_start | input | 1 | Pulse at the start of the pre-render line |
| spr0_set | input | 1 | Sprite-0 hit event |
| ovf_set | input | 1 | Sprite overflow event |
| pal_in | input | 8 | Palette value before masking |
| pal_out | output | 8 | Palette value after masking |
| nmi_en | output | 1 | Control: interrupt enable |
| ext_out_en | output | 1 | Control: drive colour on the external port |
| spr_tall | output | 1 | Control: 8x16 sprites |
| bg_table | output | 1 | Control: background pattern half |
| spr_table | output | 1 | Control: sprite pattern half |
| step_wide | output | 1 | Control: address step of 32 |
| nt_base | output | 2 | Control: starting nametable |
| emph | output | 3 | Mask: colour emphasis |
| spr_en | output | 1 | Mask: sprites enabled |
| bg_en | output | 1 | Mask: background enabled |
| spr_left | output | 1 | Mask: sprites in the left 8 columns |
| bg_left | output | 1 | Mask: background in the left 8 columns |
| mono | output | 1 | Mask: monochrome |
| bus_active | output | 1 | Video memory bus in use |
| nmi | output | 1 | Vertical-blank interrupt |
| vaddr | output | 14 | Video-memory address |
| addr_step | output | 6 | Current address increment |

## Verification
The assertions assume that each timing and event input is a single-cycle pulse. They also assume that `prerender_start` never arrives in the same cycle as `vblank_start`, because the raster counter places the two about 20 lines apart. The bench drives every pulse for exactly one cycle. It fires `vblank_start` and `prerender_start` in separate steps, and it tests same-cycle arrival only for the collisions that R12 defines. Each CPU access lasts one cycle with `bus_cs` high, so every access causes exactly one side effect.

// File: rtl/vid_regif_pkg.sv
// Shared field layouts for the video register interface.
// Assumes packed structs are laid out from the MSB down, matching the bus byte.
package vid_regif_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic       nmi_en;
        logic       ext_out_en;
        logic       spr_tall;
        logic       bg_table;
        logic       spr_table;
        logic       step_wide;
        logic [1:0] nt_base;
    } ctrl_t;

    typedef struct packed {
        logic [2:0] emph;
        logic       spr_en;
        logic       bg_en;
        logic       spr_left;
        logic       bg_left;
        logic       mono;
    } mask_t;
endpackage

// File: rtl/vid_cfg_regs.sv
// Write-only control and mask registers.
// Assumes that at most one write strobe is high in any cycle.
module vid_cfg_regs
    import vid_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              mask_we,
    input  logic [BYTE_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output mask_t             mask_q
);
    // Load the control byte; cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_t'(wdata);
    end

    // Load the mask byte; cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_t'(wdata);
    end
endmodule

// File: rtl/vid_status.sv
// Status flags and the open-bus latch.
// Assumes single-cycle event pulses. A vblank set wins over a clear in the
// same cycle. A prerender clear wins over the sprite set pulses.
module vid_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vblank_start,
    input  logic              prerender_start,
    input  logic              hit_set,
    input  logic              ovf_set,
    input  logic              stat_rd,
    input  logic              capture,
    input  logic [DATA_W-1:0] capture_val,
    output logic              vbl,
    output logic              hit,
    output logic              ovf,
    output logic [DATA_W-1:0] open_q
);
    // Vblank flag: set at vblank start, cleared by a status read or by prerender.
    always_ff @(posedge clk) begin
        if (!rst_n)                          vbl <= 1'b0;
        else if (vblank_start)               vbl <= 1'b1;
        else if (prerender_start || stat_rd) vbl <= 1'b0;
    end

    // Sprite-0 hit flag: sticky until prerender.
    always_ff @(posedge clk) begin
        if (!rst_n)               hit <= 1'b0;
        else if (prerender_start) hit <= 1'b0;
        else if (hit_set)         hit <= 1'b1;
    end

    // Overflow flag: sticky until prerender.
    always_ff @(posedge clk) begin
        if (!rst_n)               ovf <= 1'b0;
        else if (prerender_start) ovf <= 1'b0;
        else if (ovf_set)         ovf <= 1'b1;
    end

    // Open-bus latch: holds the last byte seen on the data bus.
    always_ff @(posedge clk) begin
        if (!rst_n)       open_q <= '0;
        else if (capture) open_q <= capture_val;
    end
endmodule

// File: rtl/vid_vaddr.sv
// Video-memory address counter.
// Assumes at most one data-port access per cycle. The address wraps at 2**ADDR_W.
module vid_vaddr #(
    parameter int ADDR_W   = 14,
    parameter int WIDE_STP = 32,
    localparam int STEP_W  = $clog2(WIDE_STP) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              wide,
    output logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] vaddr
);
    // Choose the increment from the control field.
    always_comb begin
        step = wide ? STEP_W'(WIDE_STP) : STEP_W'(1);
    end

    // Advance the address once per data-port access, wrapping on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)       vaddr <= '0;
        else if (step_en) vaddr <= vaddr + ADDR_W'(step);
    end
endmodule

// File: rtl/vid_regif.sv
// Top level of the video processor CPU register interface.
// Decodes CPU accesses, forms the read data, and exposes the register fields.
// Assumes bus_cs is high for exactly one cycle per access.
module vid_regif
    import vid_regif_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int SEL_W    = 3,
    parameter int WIDE_STP = 32,
    parameter logic [SEL_W-1:0] SEL_CTRL = 3'd0,
    parameter logic [SEL_W-1:0] SEL_MASK = 3'd1,
    parameter logic [SEL_W-1:0] SEL_STAT = 3'd2,
    parameter logic [SEL_W-1:0] SEL_DATA = 3'd7,
    parameter logic [7:0]       MONO_AND = 8'h30,
    localparam int STEP_W = $clog2(WIDE_STP) + 1,
    localparam int OPEN_W = BYTE_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_wr,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              vblank_start,
    input  logic              prerender_start,
    input  logic              spr0_set,
    input  logic              ovf_set,
    input  logic [BYTE_W-1:0] pal_in,
    output logic [BYTE_W-1:0] pal_out,
    output logic              nmi_en,
    output logic              ext_out_en,
    output logic              spr_tall,
    output logic              bg_table,
    output logic              spr_table,
    output logic              step_wide,
    output logic [1:0]        nt_base,
    output logic [2:0]        emph,
    output logic              spr_en,
    output logic              bg_en,
    output logic              spr_left,
    output logic              bg_left,
    output logic              mono,
    output logic              bus_active,
    output logic              nmi,
    output logic [ADDR_W-1:0] vaddr,
    output logic [STEP_W-1:0] addr_step
);
    ctrl_t             ctrl_q;
    mask_t             mask_q;
    logic              wr_acc, rd_acc;
    logic              vbl_flag, hit_flag, ovf_flag;
    logic [BYTE_W-1:0] open_q;
    logic [BYTE_W-1:0] cap_val;

    // Classify the current bus cycle.
    always_comb begin
        wr_acc = bus_cs && bus_wr;
        rd_acc = bus_cs && !bus_wr;
    end

    vid_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (wr_acc && (bus_sel == SEL_CTRL)),
        .mask_we (wr_acc && (bus_sel == SEL_MASK)),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_q),
        .mask_q  (mask_q)
    );

    // Read data: the status byte at the status select, otherwise the open-bus latch.
    always_comb begin
        if (rd_acc && (bus_sel == SEL_STAT))
            bus_rdata = {vbl_flag, hit_flag, ovf_flag, open_q[OPEN_W-1:0]};
        else
            bus_rdata = open_q;
        cap_val = bus_wr ? bus_wdata : bus_rdata;
    end

    vid_status #(.DATA_W(BYTE_W)) u_stat (
        .clk             (clk),
        .rst_n           (rst_n),
        .vblank_start    (vblank_start),
        .prerender_start (prerender_start),
        .hit_set         (spr0_set),
        .ovf_set         (ovf_set),
        .stat_rd         (rd_acc && (bus_sel == SEL_STAT)),
        .capture         (bus_cs),
        .capture_val     (cap_val),
        .vbl             (vbl_flag),
        .hit             (hit_flag),
        .ovf             (ovf_flag),
        .open_q          (open_q)
    );

    vid_vaddr #(.ADDR_W(ADDR_W), .WIDE_STP(WIDE_STP)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (bus_cs && (bus_sel == SEL_DATA)),
        .wide    (ctrl_q.step_wide),
        .step    (addr_step),
        .vaddr   (vaddr)
    );

    // Drive the field outputs, the palette mask and the interrupt.
    always_comb begin
        nmi_en     = ctrl_q.nmi_en;
        ext_out_en = ctrl_q.ext_out_en;
        spr_tall   = ctrl_q.spr_tall;
        bg_table   = ctrl_q.bg_table;
        spr_table  = ctrl_q.spr_table;
        step_wide  = ctrl_q.step_wide;
        nt_base    = ctrl_q.nt_base;
        emph       = mask_q.emph;
        spr_en     = mask_q.spr_en;
        bg_en      = mask_q.bg_en;
        spr_left   = mask_q.spr_left;
        bg_left    = mask_q.bg_left;
        mono       = mask_q.mono;
        bus_active = mask_q.spr_en || mask_q.bg_en;
        pal_out    = mask_q.mono ? (pal_in & MONO_AND) : pal_in;
        nmi        = ctrl_q.nmi_en && vbl_flag;
    end
endmodule

// File: rtl/vid_regif_chk.sv
// Assertion checker for vid_regif, attached to it with bind.
// Assumes single-cycle pulses and that vblank_start and prerender_start never coincide.
module vid_regif_chk #(
    parameter int ADDR_W = 14,
    parameter int SEL_W  = 3,
    parameter logic [SEL_W-1:0] SEL_DATA = 3'd7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs,
    input logic [SEL_W-1:0]  bus_sel,
    input logic              vblank_start,
    input logic              prerender_start,
    input logic              nmi,
    input logic              nmi_en,
    input logic              vbl,
    input logic              hit,
    input logic              ovf,
    input logic [ADDR_W-1:0] vaddr
);
    // R5
    vbl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_start |=> vbl);

    // R6
    sprite_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prerender_start |=> (!hit && !ovf));

    // R5
    vbl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prerender_start && !vblank_start) |=> !vbl);

    // R6
    hit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !prerender_start) |=> hit);

    // R4
    vaddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && (bus_sel == SEL_DATA)) |=> $stable(vaddr));

    // R9
    nmi_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_en && vbl) |-> nmi);
endmodule

bind vid_regif vid_regif_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .SEL_DATA(SEL_DATA)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_cs          (bus_cs),
    .bus_sel         (bus_sel),
    .vblank_start    (vblank_start),
    .prerender_start (prerender_start),
    .nmi             (nmi),
    .nmi_en          (nmi_en),
    .vbl             (vbl_flag),
    .hit             (hit_flag),
    .ovf             (ovf_flag),
    .vaddr           (vaddr)
);

// File: tb/vid_regif_bench.sv
// Self-checking bench for vid_regif: register sweeps, address wrap and flag events.
module vid_regif_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_cs = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_sel = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic vblank_start = 1'b0, prerender_start = 1'b0, spr0_set = 1'b0, ovf_set = 1'b0;
    logic [7:0] pal_in = '0, pal_out;
    logic nmi_en, ext_out_en, spr_tall, bg_table, spr_table, step_wide;
    logic [1:0] nt_base;
    logic [2:0] emph;
    logic spr_en, bg_en, spr_left, bg_left, mono, bus_active, nmi;
    logic [13:0] vaddr;
    logic [5:0] addr_step;

    int total = 0, bad = 0;
    logic [7:0] ob = '0;
    logic [13:0] exp_addr = '0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    vid_regif u_vid_regif (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0;
        ob = d;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_wr = 1'b0; bus_sel = s;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_cs = 1'b0;
        ob = d;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: vblank_start = 1'b1;
            1: prerender_start = 1'b1;
            2: spr0_set = 1'b1;
            default: ovf_set = 1'b1;
        endcase
        @(negedge clk);
        vblank_start = 1'b0; prerender_start = 1'b0; spr0_set = 1'b0; ovf_set = 1'b0;
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {nmi_en, ext_out_en, spr_tall, bg_table, spr_table, step_wide, nt_base}, 0);
        chk("R1", {emph, spr_en, bg_en, spr_left, bg_left, mono, bus_active, nmi}, 0);
        chk("R1", vaddr, 0);
        rd(3'd2, rv);
        chk("R1", rv, 0);

        // R2 control field sweep
        for (int v = 0; v < 256; v++) begin
            wr(3'd0, 8'(v));
            chk("R2", {nmi_en, ext_out_en, spr_tall, bg_table, spr_table, step_wide, nt_base}, v);
            chk("R4", addr_step, (v & 4) ? 32 : 1);
        end
        wr(3'd0, 8'h00);

        // R3/R11/R10 mask sweep with palette masking
        for (int v = 0; v < 256; v++) begin
            wr(3'd1, 8'(v));
            chk("R3", {emph, spr_en, bg_en, spr_left, bg_left, mono}, v);
            chk("R11", bus_active, ((v >> 3) & 3) != 0);
            pal_in = 8'(v * 37 + 11);
            #1 chk("R10", pal_out, (v & 1) ? (pal_in & 8'h30) : pal_in);
        end
        wr(3'd1, 8'h01);
        for (int p = 0; p < 256; p++) begin
            pal_in = 8'(p);
            #1 chk("R10", pal_out, p & 8'h30);
        end
        wr(3'd1, 8'h00);
        for (int p = 0; p < 256; p += 17) begin
            pal_in = 8'(p);
            #1 chk("R10", pal_out, p);
        end

        // R4 address stepping and wrap
        wr(3'd7, 8'h12); rd(3'd7, rv); wr(3'd7, 8'h34);
        exp_addr = 14'd3;
        chk("R4", vaddr, exp_addr);
        wr(3'd3, 8'h55); rd(3'd5, rv); wr(3'd2, 8'h66);
        chk("R4", vaddr, exp_addr);
        wr(3'd0, 8'h04);
        for (int i = 0; i < 512; i++) begin
            if (i % 2 == 0) wr(3'd7, 8'(i)); else rd(3'd7, rv);
            exp_addr = exp_addr + 14'd32;
            if (i == 510) chk("R4", vaddr, exp_addr);
        end
        chk("R4", vaddr, 14'd3);
        wr(3'd0, 8'h00);

        // R8 open bus on writes and reads of other selects
        wr(3'd3, 8'hA5);
        rd(3'd0, rv);
        chk("R8", rv, 8'hA5);
        rd(3'd6, rv);
        chk("R8", rv, 8'hA5);

        // R5/R7 vblank flag set and cleared by read
        pulse(0);
        rd(3'd2, rv);
        chk("R7", rv, {3'b100, 5'h05});
        rd(3'd2, rv);
        chk("R5", rv, {3'b000, 5'h05});
        chk("R8", ob, 8'h05);

        // R6 sprite flags persist across reads
        wr(3'd4, 8'h1E);
        pulse(2); pulse(3);
        rd(3'd2, rv);
        chk("R6", rv, {3'b011, 5'h1E});
        rd(3'd2, rv);
        chk("R6", rv, 8'h7E);
        pulse(0);
        pulse(1);
        rd(3'd2, rv);
        chk("R6", rv, 8'h1E);
        chk("R5", nmi, 0);

        // R9 nmi follows enable and flag
        pulse(0);
        chk("R9", nmi, 0);
        wr(3'd0, 8'h80);
        chk("R9", nmi, 1);
        rd(3'd2, rv);
        chk("R9", nmi, 0);
        pulse(0);
        chk("R9", nmi, 1);
        pulse(1);
        chk("R9", nmi, 0);

        // R12 same-cycle collisions
        @(negedge clk);
        bus_cs = 1'b1; bus_wr = 1'b0; bus_sel = 3'd2; vblank_start = 1'b1;
        #1 rv = bus_rdata;
        @(negedge clk);
        bus_cs = 1'b0; vblank_start = 1'b0;
        chk("R12", rv[7], 0);
        chk("R12", nmi, 1);
        @(negedge clk);
        prerender_start = 1'b1; spr0_set = 1'b1; ovf_set = 1'b1;
        @(negedge clk);
        prerender_start = 1'b0; spr0_set = 1'b0; ovf_set = 1'b0;
        rd(3'd2, rv);
        chk("R12", rv[7:5], 3'b000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule